// File: doc/BRIEF.md
# Receive Character Queue with Flow-Control Request

This block sits behind the bit-level receiver of a serial port. Each completed character arrives as a one-cycle strobe with its data byte and goes into a small first-in first-out queue. A consumer drains the queue through a valid/ready read port. The block tells the far-end transmitter to pause by raising an active-high stop request, `rts_stop`. The request is derived directly from how many characters the queue holds.

The stop request rises once the queue level reaches a programmable high mark. The high mark can be at most one below the queue depth. This keeps one slot free for the character that is still shifting in when the request goes up. An optional hysteresis mode holds the request until the level drains down to a separate low mark. A character that arrives at a full queue is discarded and sets a sticky overrun flag. A status output shows whether the level is at or above the high mark.

Top module: `rxq_rts_fifo`

## Requirements
- R1: After reset the queue is empty (`rd_valid`=0, `level`=0), `rts_stop`=0, `overrun`=0, the high mark is 7 and the low mark is 3.
- R2: Characters leave in the order they arrived. `rd_valid` is 1 exactly when `level` is non-zero, and `rd_data` shows the oldest character. A push and a pop in the same cycle leave `level` unchanged. A pop while empty is ignored.
- R3: `level` counts the stored characters and changes on the clock edge that accepts a push or pop. With flow control on and hysteresis off, `rts_stop` is 1 exactly when `level` >= high mark, so it changes on the edge that writes the character. With the high mark at 7 it rises at 7 entries, not 8.
- R4: On a `cfg_wr` strobe the high mark is loaded from `cfg_hi`, clamped to the range 1 to 7 (0 becomes 1; 8 to 15 become 7). The low mark is loaded from `cfg_lo`, clamped to at most the high mark minus 1.
- R5: With `hyst_en`=1, `rts_stop` rises when `level` reaches the high mark. It stays 1 while `level` is above the low mark and falls once `level` is at or below the low mark.
- R6: A push while the queue holds 8 characters and no pop is accepted in that cycle is dropped. It sets `overrun`, and the stored characters and `level` are kept. A push to a full queue that coincides with a pop is accepted.
- R7: `overrun` stays 1 until an `ovr_clr` strobe. If a clear and a new dropped character happen in the same cycle, `overrun` stays 1.
- R8: With `fc_en`=0, `rts_stop` is 0 whatever the level.
- R9: `at_mark` is 1 exactly when `level` >= high mark, independent of `fc_en` and `hyst_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a character has completed |
| rx_data | input | 8 | Completed character |
| rd_ready | input | 1 | Consumer accepts the head character |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_data | output | 8 | Oldest stored character |
| fc_en | input | 1 | Enables the stop request |
| hyst_en | input | 1 | Selects the high/low mark hysteresis mode |
| cfg_wr | input | 1 | Loads both marks |
| cfg_hi | input | 4 | Requested high mark |
| cfg_lo | input | 4 | Requested low mark |
| ovr_clr | input | 1 | Clears the overrun flag |
| rts_stop | output | 1 | 1 = ask the far end to stop sending |
| level | output | 4 | Number of stored characters |
| overrun | output | 1 | Sticky flag: a character was dropped |
| at_mark | output | 1 | Level is at or above the high mark |

## Verification
The assertions assume `rx_valid` is a single-cycle strobe, so the level moves by at most one per cycle. They also assume the marks change only through `cfg_wr` and never change in the same cycle as a push. The bench meets these conditions by driving each strobe for exactly one cycle, on the falling edge. It writes the marks only while the queue is idle, and drains the queue between scenarios so each one starts empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Clamp an unsigned value into [lo_lim, hi_lim].
    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo_lim,
                                            input int unsigned hi_lim);
        if (v < lo_lim) return lo_lim;
        if (v > hi_lim) return hi_lim;
        return v;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          ovr_clr,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head_data,
    output logic          ovr
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     ovr;
    } st_t;

    st_t  s_q, s_d;
    logic full, pop, accept, drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        full   = (s_q.cnt == CW'(DEPTH));
        pop    = pop_req && (s_q.cnt != '0);
        accept = push && (!full || pop);
        drop   = push && full && !pop;
        if (accept) begin
            s_d.mem[s_q.wp] = push_data;
            s_d.wp          = bump(s_q.wp);
        end
        if (pop) s_d.rp = bump(s_q.rp);
        if (accept && !pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (pop && !accept) s_d.cnt = s_q.cnt - 1'b1;
        s_d.ovr = drop | (s_q.ovr & ~ovr_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count     = s_q.cnt;
    assign head_data = s_q.mem[s_q.rp];
    assign ovr       = s_q.ovr;

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R6
    drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.cnt == CW'(DEPTH) && !pop_req) |=> (ovr && $stable(count)));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push && s_q.cnt == '0) |=> (count == '0));

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow #(
    parameter int DEPTH  = 8,
    parameter int HI_RST = DEPTH - 1,
    parameter int LO_RST = DEPTH / 2 - 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [CW-1:0] cfg_hi,
    input  logic [CW-1:0] cfg_lo,
    input  logic          fc_en,
    input  logic          hyst_en,
    input  logic [CW-1:0] count,
    output logic          rts_stop,
    output logic          at_mark
);
    import rxq_pkg::*;

    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
        logic          hold;
    } fl_t;

    fl_t           f_q, f_d;
    logic [CW-1:0] hi_c, lo_c;
    logic          above_lo;

    always_comb begin
        f_d      = f_q;
        hi_c     = CW'(clamp_u(int'(cfg_hi), 1, DEPTH - 1));
        lo_c     = CW'(clamp_u(int'(cfg_lo), 0, int'(hi_c) - 1));
        above_lo = (count > f_q.lo);
        at_mark  = (count >= f_q.hi);
        f_d.hold = at_mark | (f_q.hold & above_lo);
        if (cfg_wr) begin
            f_d.hi = hi_c;
            f_d.lo = lo_c;
        end
        rts_stop = fc_en & (at_mark | (hyst_en & f_q.hold & above_lo));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.hi   <= CW'(HI_RST);
            f_q.lo   <= CW'(LO_RST);
            f_q.hold <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    // R4
    hi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.hi >= CW'(1) && f_q.hi <= CW'(DEPTH - 1));

    // R4
    lo_below_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.lo < f_q.hi);

    // R5
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && hyst_en && rts_stop && !cfg_wr) |=>
            (!(fc_en && hyst_en && count > f_q.lo) || rts_stop));

endmodule

// File: rtl/rxq_rts_fifo.sv
module rxq_rts_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          fc_en,
    input  logic          hyst_en,
    input  logic          cfg_wr,
    input  logic [CW-1:0] cfg_hi,
    input  logic [CW-1:0] cfg_lo,
    input  logic          ovr_clr,
    output logic          rts_stop,
    output logic [CW-1:0] level,
    output logic          overrun,
    output logic          at_mark
);

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop_req   (rd_ready),
        .ovr_clr   (ovr_clr),
        .count     (level),
        .head_data (rd_data),
        .ovr       (overrun)
    );

    rxq_flow #(.DEPTH(DEPTH)) u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_hi   (cfg_hi),
        .cfg_lo   (cfg_lo),
        .fc_en    (fc_en),
        .hyst_en  (hyst_en),
        .count    (level),
        .rts_stop (rts_stop),
        .at_mark  (at_mark)
    );

    assign rd_valid = (level != '0);

    // R8
    fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |-> !rts_stop);

    // R3
    full_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && level == CW'(DEPTH)) |-> rts_stop);

endmodule

// File: tb/rxq_rts_fifo_tb.sv
module rxq_rts_fifo_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rd_ready = 0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       fc_en = 0, hyst_en = 0, cfg_wr = 0, ovr_clr = 0;
    logic [3:0] cfg_hi = 0, cfg_lo = 0;
    logic       rts_stop, overrun, at_mark;
    logic [3:0] level;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxq_rts_fifo u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_valid = 1; rx_data = d;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic pop();
        @(negedge clk); rd_ready = 1;
        @(negedge clk); rd_ready = 0;
    endtask

    task automatic cfg(input logic [3:0] hi, input logic [3:0] lo);
        @(negedge clk); cfg_wr = 1; cfg_hi = hi; cfg_lo = lo;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic drain();
        while (rd_valid) pop();
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 level", level, 0);
        chk("R1 rts_stop", rts_stop, 0);
        chk("R1 overrun", overrun, 0);
        fc_en = 1;
        for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
        chk("R1 default high mark, 6 entries", rts_stop, 0);
        push(8'h16);
        chk("R1 default high mark, 7 entries", rts_stop, 1);
        hyst_en = 1;
        pop(); pop(); pop();
        chk("R1 default low mark, level 4", rts_stop, 1);
        pop();
        chk("R1 default low mark, level 3", rts_stop, 0);
        hyst_en = 0;
        drain();
    endtask

    task automatic t_fill_overrun();
        fc_en = 1;
        for (int i = 0; i < 6; i++) push(8'hA0 + 8'(i));
        chk("R3 level 6", level, 6);
        chk("R3 no stop at 6", rts_stop, 0);
        chk("R9 at_mark at 6", at_mark, 0);
        push(8'hA6);
        chk("R3 stop at 7", rts_stop, 1);
        chk("R9 at_mark at 7", at_mark, 1);
        push(8'hA7);
        chk("R3 level 8", level, 8);
        push(8'hEE);
        chk("R6 level kept", level, 8);
        chk("R6 overrun set", overrun, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R2 order", rd_data, 8'hA0 + i);
            pop();
            if (i == 1) chk("R3 release below mark", rts_stop, 0);
        end
        chk("R2 empty", rd_valid, 0);
    endtask

    task automatic t_ovr_clear();
        @(negedge clk); ovr_clr = 1;
        @(negedge clk); ovr_clr = 0;
        chk("R7 cleared", overrun, 0);
        for (int i = 0; i < 8; i++) push(8'(i));
        @(negedge clk); ovr_clr = 1; rx_valid = 1;
        @(negedge clk); ovr_clr = 0; rx_valid = 0;
        chk("R7 new overrun wins", overrun, 1);
        @(negedge clk); rd_ready = 1; rx_valid = 1; rx_data = 8'h55;
        @(negedge clk); rd_ready = 0; rx_valid = 0;
        chk("R6 full push with pop accepted", level, 8);
        for (int i = 0; i < 7; i++) pop();
        chk("R6 pushed char at tail", rd_data, 8'h55);
        drain();
        @(negedge clk); ovr_clr = 1;
        @(negedge clk); ovr_clr = 0;
    endtask

    task automatic t_pushpop();
        push(8'h31);
        @(negedge clk); rd_ready = 1; rx_valid = 1; rx_data = 8'h32;
        @(negedge clk); rd_ready = 0; rx_valid = 0;
        chk("R2 push+pop level", level, 1);
        chk("R2 push+pop head", rd_data, 8'h32);
        pop();
        pop();
        chk("R2 pop on empty ignored", level, 0);
    endtask

    task automatic t_clamp();
        fc_en = 1;
        cfg(4'd0, 4'd0);
        push(8'h01);
        chk("R4 hi 0 clamps to 1", rts_stop, 1);
        drain();
        cfg(4'd15, 4'd15);
        for (int i = 0; i < 6; i++) push(8'(i));
        chk("R4 hi 15 clamps, 6 entries", rts_stop, 0);
        push(8'h06);
        chk("R4 hi 15 clamps, 7 entries", rts_stop, 1);
        hyst_en = 1;
        pop();
        chk("R4 lo clamped to 6, level 6", rts_stop, 0);
        hyst_en = 0;
        drain();
    endtask

    task automatic t_hyst();
        fc_en = 1; hyst_en = 1;
        cfg(4'd6, 4'd2);
        for (int i = 0; i < 6; i++) push(8'(i));
        chk("R5 rises at high mark", rts_stop, 1);
        pop(); pop(); pop();
        chk("R5 held at level 3", rts_stop, 1);
        pop();
        chk("R5 falls at low mark", rts_stop, 0);
        push(8'h09);
        chk("R5 stays low below high mark", rts_stop, 0);
        hyst_en = 0;
        drain();
    endtask

    task automatic t_fc_off();
        fc_en = 0;
        cfg(4'd7, 4'd3);
        for (int i = 0; i < 8; i++) push(8'(i));
        chk("R8 no stop when disabled", rts_stop, 0);
        chk("R9 at_mark independent of fc", at_mark, 1);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fill_overrun();
        t_ovr_clear();
        t_pushpop();
        t_clamp();
        t_hyst();
        t_fc_off();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule